// File: doc/BRIEF.md
# Local Bus Slave Ready Generator

This block is the slave-side handshake for a peripheral on a 32-bit synchronous local bus. It watches the address strobe and the chip decode to find the address cycle (T1) of an access aimed at the device. It then follows the T2 cycles that come after it. It decides when the device may turn on its drivers for the ready line, the burst-ready line and the data bus. It decides when the ready pulse that ends the access is given. It also performs the short active-inactive drive that comes before the ready lines are released.

Drivers stay off through T1 and the first T2. They come on at the second T2 at the earliest, so the block always meets the stricter hold-off rule, whatever the high-speed write indication says. Ready is asserted once the internal logic reports read data or a write acknowledgement, which can add T2 wait cycles. In the cycle that follows ready, both ready lines are driven high for the first half of the clock. A falling-edge register then releases them at mid-cycle. The behaviour is the same in every operating mode of the device.

Top module: `lbs_ready_gen`

## Requirements
- R1: During T1 and the first T2 of an access, `ready_oe`, `burst_ready_oe` and `data_oe` are all 0. The earliest cycle with any of them at 1 is the second T2.
- R2: A T1 is accepted only when the rising edge samples `addr_strobe_n` = 0 together with `dev_sel` = 1, and the block is idle or in the release cycle. A strobe while an access is in progress, or a strobe without `dev_sel`, changes nothing at the outputs.
- R3: `ready_l` and `burst_ready_l` go low together, for exactly one cycle. That cycle follows the first rising edge, at or after the end of the first T2, that samples `resp_valid` = 1. With `resp_valid` already high in the first T2, the ready cycle is the second T2.
- R4: From the second T2 until ready, both ready outputs are enabled and held high (inactive). A low level appears only while its enable is 1.
- R5: In the cycle after the ready cycle, both ready enables stay 1 with the levels high until the falling clock edge, and are 0 from that edge on.
- R6: `data_oe` is 1 only for reads (`is_write` = 0 sampled at T1), from the second T2 through the ready cycle. It is 0 in the release cycle and for every write.
- R7: `fast_write` has no effect on any output.
- R8: While `rst` is high, every enable is 0 and both ready levels are 1.
- R9: The release cycle may itself be the T1 of the next access. That access then follows R1 to R6 with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_strobe_n | input | 1 | Address strobe, active low, marks T1 |
| dev_sel | input | 1 | Address decode hit for this device |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| resp_valid | input | 1 | Internal read data or write acknowledgement available |
| fast_write | input | 1 | High-speed write indication, not used |
| ready_l | output | 1 | Ready level, active low |
| ready_oe | output | 1 | Driver enable for the ready line |
| burst_ready_l | output | 1 | Burst-ready level, active low |
| burst_ready_oe | output | 1 | Driver enable for the burst-ready line |
| data_oe | output | 1 | Driver enable for the data bus on reads |

## Verification
The assertions assume two things about the inputs. The internal logic raises `resp_valid` only for an access in progress and keeps it high until the ready cycle. The strobe and the decode are stable around the rising edge. The stimulus changes inputs 1 ns after each rising edge and holds `resp_valid` from its chosen start cycle up to the ready cycle. It also pushes extra strobes and a random `fast_write` into the middle of accesses, which are cases the assertions must treat as noise. It samples each cycle both before and after the falling edge, so the half-cycle release is visible.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_WAIT,
        PH_READY,
        PH_TAIL
    } lbs_phase_e;

    typedef struct packed {
        logic oe;
        logic lvl;
    } lbs_line_t;

    function automatic logic ph_drives(lbs_phase_e p);
        return (p == PH_WAIT) || (p == PH_READY);
    endfunction

    function automatic logic ph_accepts_t1(lbs_phase_e p);
        return (p == PH_IDLE) || (p == PH_TAIL);
    endfunction

endpackage

// File: rtl/lbs_phase_fsm.sv
`timescale 1ns/1ps
module lbs_phase_fsm
    import lbs_pkg::*;
#(
    parameter int DRIVE_T2 = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_n,
    input  logic       sel,
    input  logic       is_write,
    input  logic       resp_valid,
    output lbs_phase_e phase,
    output logic       rd_acc
);
    localparam int CNT_W = $clog2(DRIVE_T2 + 1);
    localparam logic [CNT_W-1:0] LAST_HOLD = CNT_W'(DRIVE_T2 - 1);

    logic [CNT_W-1:0] t2_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            t2_cnt <= '0;
            rd_acc <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE, PH_TAIL: begin
                    if (!strobe_n && sel) begin
                        phase  <= PH_HOLD;
                        t2_cnt <= CNT_W'(1);
                        rd_acc <= !is_write;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                PH_HOLD: begin
                    if (t2_cnt == LAST_HOLD) begin
                        phase <= resp_valid ? PH_READY : PH_WAIT;
                    end else begin
                        t2_cnt <= t2_cnt + CNT_W'(1);
                    end
                end
                PH_WAIT: begin
                    if (resp_valid) begin
                        phase <= PH_READY;
                    end
                end
                PH_READY: phase <= PH_TAIL;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R2: a strobe during a wait does not restart the access
    a_r2_wait_ignores_strobe: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && !resp_valid) |=> (phase == PH_WAIT));

    // R3: a wait ends in the ready phase once the response is present
    a_r3_wait_to_ready: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && resp_valid) |=> (phase == PH_READY));

endmodule

// File: rtl/lbs_ready_lane.sv
`timescale 1ns/1ps
module lbs_ready_lane
    import lbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lbs_phase_e phase,
    output lbs_line_t  line
);
    logic mid_hold;

    // captured at mid-cycle: keeps the driver on for the first half of the release cycle
    always_ff @(negedge clk) begin
        if (rst) begin
            mid_hold <= 1'b0;
        end else begin
            mid_hold <= ph_drives(phase);
        end
    end

    always_comb begin
        line.oe  = ph_drives(phase) || ((phase == PH_TAIL) && mid_hold);
        line.lvl = (phase != PH_READY);
    end

endmodule

// File: rtl/lbs_ready_gen.sv
`timescale 1ns/1ps
module lbs_ready_gen
    import lbs_pkg::*;
#(
    parameter int DRIVE_T2 = 2,
    parameter int N_LINES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic addr_strobe_n,
    input  logic dev_sel,
    input  logic is_write,
    input  logic resp_valid,
    input  logic fast_write,
    output logic ready_l,
    output logic ready_oe,
    output logic burst_ready_l,
    output logic burst_ready_oe,
    output logic data_oe
);
    lbs_phase_e phase;
    logic       rd_acc;
    lbs_line_t  lines [N_LINES];
    logic       unused_fast_write;

    assign unused_fast_write = fast_write;

    lbs_phase_fsm #(.DRIVE_T2(DRIVE_T2)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .strobe_n   (addr_strobe_n),
        .sel        (dev_sel),
        .is_write   (is_write),
        .resp_valid (resp_valid),
        .phase      (phase),
        .rd_acc     (rd_acc)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_lane
        lbs_ready_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .phase (phase),
            .line  (lines[g])
        );
    end

    assign ready_l        = lines[0].lvl;
    assign ready_oe       = lines[0].oe;
    assign burst_ready_l  = lines[N_LINES-1].lvl;
    assign burst_ready_oe = lines[N_LINES-1].oe;
    assign data_oe        = ph_drives(phase) && rd_acc;

    // R1: nothing is driven in the first T2
    a_r1_quiet_first_t2: assert property (@(posedge clk) disable iff (rst)
        (ph_accepts_t1(phase) && !addr_strobe_n && dev_sel)
        |=> (!ready_oe && !burst_ready_oe && !data_oe));

    // R3: ready falls only after the response was seen
    a_r3_ready_needs_resp: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_l) |-> $past(resp_valid));

    // R3: ready is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        !ready_l |=> ready_l);

    // R4: a low level only while driven
    a_r4_low_is_driven: assert property (@(posedge clk) disable iff (rst)
        (!ready_l |-> ready_oe) and (!burst_ready_l |-> burst_ready_oe));

    // R6: data drivers only together with ready drivers
    a_r6_data_with_ready: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ready_oe);

endmodule

// File: tb/test_lbs_ready_gen.sv
`timescale 1ns/1ps
module test_lbs_ready_gen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_strobe_n = 1'b1;
    logic dev_sel = 1'b0;
    logic is_write = 1'b0;
    logic resp_valid = 1'b0;
    logic fast_write = 1'b0;
    logic ready_l, ready_oe, burst_ready_l, burst_ready_oe, data_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lbs_ready_gen i_lbs_ready_gen (
        .clk            (clk),
        .rst            (rst),
        .addr_strobe_n  (addr_strobe_n),
        .dev_sel        (dev_sel),
        .is_write       (is_write),
        .resp_valid     (resp_valid),
        .fast_write     (fast_write),
        .ready_l        (ready_l),
        .ready_oe       (ready_oe),
        .burst_ready_l  (burst_ready_l),
        .burst_ready_oe (burst_ready_oe),
        .data_oe        (data_oe)
    );

    task automatic chk(string req, string what, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic chk_all(string req, logic e_oe, logic e_lvl, logic e_doe);
        chk(req, "ready_oe", ready_oe, e_oe);
        chk(req, "burst_ready_oe", burst_ready_oe, e_oe);
        chk(req, "ready_l", ready_l, e_lvl);
        chk(req, "burst_ready_l", burst_ready_l, e_lvl);
        chk(req, "data_oe", data_oe, e_doe);
    endtask

    // one access; c = first cycle (T1 = 0) with resp_valid high; ready cycle r = max(c,1)+1
    task automatic access(logic w, int c, bit noisy, bit chained_in, bit chain_out, logic w_next);
        int r;
        r = ((c > 1) ? c : 1) + 1;
        if (!chained_in) begin
            @(posedge clk); #1;
            addr_strobe_n = 1'b0; dev_sel = 1'b1; is_write = w;
            resp_valid = (c == 0); fast_write = 1'($urandom);
            #1 chk_all("R2 idle before T1", 1'b0, 1'b1, 1'b0);
        end
        for (int n = 1; n <= r + 1; n++) begin
            @(posedge clk); #1;
            fast_write = 1'($urandom);
            if (n == r + 1) begin
                resp_valid    = 1'b0;
                addr_strobe_n = chain_out ? 1'b0 : 1'b1;
                dev_sel       = chain_out;
                is_write      = chain_out ? w_next : 1'b0;
            end else begin
                resp_valid    = (n >= c);
                addr_strobe_n = noisy ? 1'b0 : 1'b1;
                dev_sel       = noisy;
                is_write      = noisy ? ~w : 1'b0;
            end
            #1;
            if (n == 1) begin
                chk_all("R1 first T2 early", 1'b0, 1'b1, 1'b0);
                #1.5 chk_all("R1 first T2 late", 1'b0, 1'b1, 1'b0);
            end else if (n < r) begin
                chk_all("R4 wait early", 1'b1, 1'b1, !w);
                #1.5 chk_all("R4 wait late R6 R7", 1'b1, 1'b1, !w);
            end else if (n == r) begin
                chk_all("R3 ready early", 1'b1, 1'b0, !w);
                #1.5 chk_all("R3 ready late R6", 1'b1, 1'b0, !w);
            end else begin
                chk_all("R5 release first half", 1'b1, 1'b1, 1'b0);
                #1.5 chk_all("R5 release second half", 1'b0, 1'b1, 1'b0);
            end
        end
        if (!chain_out) begin
            @(posedge clk); #1;
            addr_strobe_n = 1'b1; dev_sel = 1'b0;
            #1 chk_all("R2 idle after access", 1'b0, 1'b1, 1'b0);
        end
    endtask

    initial begin
        // R8: reset state
        repeat (2) @(posedge clk);
        #2 chk_all("R8 reset", 1'b0, 1'b1, 1'b0);
        @(posedge clk); #1 rst = 1'b0;

        // R2: strobe without select is ignored
        @(posedge clk); #1 addr_strobe_n = 1'b0; dev_sel = 1'b0;
        @(posedge clk); #1 addr_strobe_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #2 chk_all("R2 unselected strobe", 1'b0, 1'b1, 1'b0);
        end

        // sweep: direction x response delay x strobe noise
        for (int w = 0; w < 2; w++)
            for (int c = 0; c < 6; c++)
                for (int nz = 0; nz < 2; nz++)
                    access(1'(w), c, bit'(nz), 1'b0, 1'b0, 1'b0);

        // R9: back-to-back accesses, T1 in the release cycle
        access(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b1);
        access(1'b1, 3, 1'b0, 1'b1, 1'b1, 1'b0);
        access(1'b0, 2, 1'b1, 1'b1, 1'b0, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule